// File: doc/BRIEF.md
# Dynamic Address Dispenser

This block sits beside the bus engine of a serial bus controller and handles the controller's part of a dynamic address assignment round. Before a round, software pushes up to `POOL_DEPTH` seven-bit addresses into a pool. Once a round is started, the block takes in the six identification bytes of each answering target from the engine's receive stream. It then raises the assignment-request bit of its pending word and waits for software to acknowledge that bit.

After the acknowledgement, the block offers the next pool address to the engine as one byte: the address sits in bits 7:1 and bit 0 is a parity bit that makes the byte's count of ones odd. Addresses go out strictly in pool order. The block counts how many it has handed out, so software can register the targets it found.

A round ends normally when the engine reports that no target answered. A refused header is the expected last event of every round and is recorded as completion, not as an error. If a target asks for an address after the pool has run dry, the round stops and an overflow status is raised instead.

Top module: `dyn_addr_dispenser`

## Requirements
- R1: After reset, `irq_pend_o` is 0, `irq_o`, `tx_valid_o`, `busy_o`, `done_o` and `overflow_o` are low, and `assigned_o` is 0.
- R2: A pulse on `pool_push_i` appends `pool_addr_i` behind the entries already in the pool, and `pool_flush_i` empties the pool. Both are ignored while `busy_o` is high.
- R3: While the block collects, each accepted `rx_data_i` byte shifts into `id_o` from the right, so the first of the six bytes ends in bits 47:40. Bytes that arrive while the block is not collecting leave `id_o` unchanged.
- R4: The clock edge that accepts the sixth identification byte sets bit 7 (assignment request) of `irq_pend_o`, as long as the pool still holds an address. `irq_o` is the OR of `irq_pend_o & irq_mask_i`.
- R5: A 1 in `irq_clr_i` clears that pending bit at the next edge, and a 0 leaves the bit unchanged. A set and a clear of the same bit on the same edge leave the bit at 1.
- R6: No address byte is offered until bit 7 is cleared. `tx_valid_o` rises at the edge that clears it. `tx_data_o` is `{addr, p}`, where p makes the number of ones in the byte odd.
- R7: Addresses are handed out in push order, starting at pool index 0 for each round. `tx_valid_o` and `tx_data_o` hold until `tx_ready_i` is high at an edge, and that edge increments `assigned_o` and ends the offer.
- R8: `no_ack_i` while collecting ends the round. `done_o` goes high, pending bit 0 is set, `busy_o` falls, and `overflow_o` stays low.
- R9: If the sixth byte of a target arrives when every pool address has been handed out, the round stops. `overflow_o` goes high, pending bit 1 is set, bit 7 is not set, and `busy_o` falls.
- R10: `round_start_i` while idle sets `busy_o`, and clears `assigned_o`, `done_o` and `overflow_o`. While busy, it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pool_push_i | input | 1 | Append `pool_addr_i` to the pool |
| pool_addr_i | input | 7 | Address to append |
| pool_flush_i | input | 1 | Empty the pool |
| round_start_i | input | 1 | Begin an assignment round |
| rx_valid_i | input | 1 | Received byte strobe from the bus engine |
| rx_data_i | input | 8 | Received identification byte |
| no_ack_i | input | 1 | Engine reports that no target answered |
| tx_valid_o | output | 1 | Address byte offered |
| tx_data_o | output | 8 | Address with odd-parity bit 0 |
| tx_ready_i | input | 1 | Engine takes the offered byte |
| irq_mask_i | input | 8 | Interrupt enable per pending bit |
| irq_clr_i | input | 8 | Write-one-to-clear pulse per pending bit |
| irq_pend_o | output | 8 | Pending word: bit 7 request, bit 1 overflow, bit 0 done |
| irq_o | output | 1 | Interrupt request |
| id_o | output | 48 | Identification bytes of the current target |
| assigned_o | output | $clog2(POOL_DEPTH+1) | Addresses handed out this round |
| busy_o | output | 1 | Round in progress |
| done_o | output | 1 | Round ended normally |
| overflow_o | output | 1 | Round stopped on an empty pool |

## Verification
Every registered result is due one edge after the stimulus that causes it. The request bit and `id_o` follow the edge that accepts the sixth byte, and `tx_valid_o` follows the edge of the clear pulse. `assigned_o` follows the accepting `tx_ready_i` edge, and the done and overflow flags follow the ending edge. `irq_o` follows the mask with no edge in between. The bench drives each stimulus on a falling edge and samples on the next falling edge, so exactly one rising edge lies between them. Mask changes are checked a short delay after they are applied.

// File: rtl/dad_pkg.sv
package dad_pkg;
  localparam int ID_BYTES   = 6;
  localparam int PEND_W     = 8;
  localparam int BIT_DONE   = 0;
  localparam int BIT_OVF    = 1;
  localparam int BIT_ASSIGN = 7;

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_WAIT, S_SEND} seq_state_e;

  // address in 7:1, bit 0 forces odd ones count
  function automatic logic [7:0] addr_byte(input logic [6:0] a);
    return {a, ~^a};
  endfunction
endpackage

// File: rtl/dad_pool.sv
module dad_pool #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [6:0]    addr_i,
  input  logic          flush_i,
  input  logic          lock_i,
  input  logic [CW-1:0] rd_idx_i,
  output logic          exhausted_o,
  output logic [7:0]    byte_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [6:0]    mem [DEPTH];
  logic [CW-1:0] fill_q;
  logic          wr_en;

  assign wr_en = !lock_i && !flush_i && push_i && (fill_q < CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else if (!lock_i) begin
      if (flush_i)    fill_q <= '0;
      else if (wr_en) fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[fill_q[AW-1:0]] <= addr_i;
  end

  assign exhausted_o = (rd_idx_i >= fill_q);
  assign byte_o      = dad_pkg::addr_byte(mem[rd_idx_i[AW-1:0]]);
endmodule

// File: rtl/dad_id_capture.sv
module dad_id_capture #(
  parameter int NB = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [7:0]    data_i,
  output logic [8*NB-1:0] id_o,
  output logic          last_o
);
  localparam int NW = (NB > 1) ? $clog2(NB) : 1;

  logic [NW-1:0]   cnt_q;
  logic [8*NB-1:0] id_q;
  logic            take;

  assign take   = en_i && valid_i;
  assign last_o = take && (cnt_q == NW'(NB - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      id_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      id_q  <= '0;
    end else if (take) begin
      id_q  <= {id_q[8*NB-9:0], data_i};
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign id_o = id_q;
endmodule

// File: rtl/dad_irq_regs.sv
module dad_irq_regs #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] pend_q;

  // set beats clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & mask_i);
endmodule

// File: rtl/dad_seq.sv
module dad_seq #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          last_i,
  input  logic          exhausted_i,
  input  logic          no_ack_i,
  input  logic          ack_i,
  input  logic          tx_ready_i,
  output logic          collect_o,
  output logic          cap_clr_o,
  output logic [7:0]    set_o,
  output logic [CW-1:0] idx_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ovf_o,
  output logic          tx_valid_o
);
  import dad_pkg::*;

  seq_state_e    state_q, state_d;
  logic [CW-1:0] idx_q, idx_d;
  logic          done_q, done_d, ovf_q, ovf_d;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    done_d    = done_q;
    ovf_d     = ovf_q;
    set_o     = '0;
    cap_clr_o = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d   = S_COLLECT;
        idx_d     = '0;
        done_d    = 1'b0;
        ovf_d     = 1'b0;
        cap_clr_o = 1'b1;
      end
      S_COLLECT: begin
        if (no_ack_i) begin
          state_d         = S_IDLE;
          done_d          = 1'b1;
          set_o[BIT_DONE] = 1'b1;
        end else if (last_i) begin
          if (exhausted_i) begin
            state_d        = S_IDLE;
            ovf_d          = 1'b1;
            set_o[BIT_OVF] = 1'b1;
          end else begin
            state_d           = S_WAIT;
            set_o[BIT_ASSIGN] = 1'b1;
          end
        end
      end
      S_WAIT: if (ack_i) state_d = S_SEND;
      S_SEND: if (tx_ready_i) begin
        state_d   = S_COLLECT;
        idx_d     = idx_q + 1'b1;
        cap_clr_o = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      ovf_q   <= ovf_d;
    end
  end

  assign collect_o  = (state_q == S_COLLECT);
  assign tx_valid_o = (state_q == S_SEND);
  assign busy_o     = (state_q != S_IDLE);
  assign idx_o      = idx_q;
  assign done_o     = done_q;
  assign ovf_o      = ovf_q;
endmodule

// File: rtl/dyn_addr_dispenser.sv
module dyn_addr_dispenser #(
  parameter int POOL_DEPTH = 16,
  localparam int CW = $clog2(POOL_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pool_push_i,
  input  logic [6:0]    pool_addr_i,
  input  logic          pool_flush_i,
  input  logic          round_start_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          no_ack_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ready_i,
  input  logic [7:0]    irq_mask_i,
  input  logic [7:0]    irq_clr_i,
  output logic [7:0]    irq_pend_o,
  output logic          irq_o,
  output logic [47:0]   id_o,
  output logic [CW-1:0] assigned_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          overflow_o
);
  import dad_pkg::*;

  logic          collect, cap_clr, last, exhausted;
  logic [7:0]    set_vec;
  logic [CW-1:0] idx;

  dad_pool #(.DEPTH(POOL_DEPTH), .CW(CW)) u_pool (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(pool_push_i), .addr_i(pool_addr_i),
    .flush_i(pool_flush_i), .lock_i(busy_o), .rd_idx_i(idx),
    .exhausted_o(exhausted), .byte_o(tx_data_o)
  );

  dad_id_capture #(.NB(ID_BYTES)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cap_clr), .en_i(collect),
    .valid_i(rx_valid_i), .data_i(rx_data_i), .id_o(id_o), .last_o(last)
  );

  dad_irq_regs #(.W(PEND_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_vec), .clr_i(irq_clr_i),
    .mask_i(irq_mask_i), .pend_o(irq_pend_o), .irq_o(irq_o)
  );

  dad_seq #(.CW(CW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(round_start_i), .last_i(last),
    .exhausted_i(exhausted), .no_ack_i(no_ack_i), .ack_i(irq_clr_i[BIT_ASSIGN]),
    .tx_ready_i(tx_ready_i), .collect_o(collect), .cap_clr_o(cap_clr),
    .set_o(set_vec), .idx_o(idx), .busy_o(busy_o), .done_o(done_o),
    .ovf_o(overflow_o), .tx_valid_o(tx_valid_o)
  );

  assign assigned_o = idx;
endmodule

// File: rtl/dyn_addr_dispenser_chk.sv
module dyn_addr_dispenser_chk #(
  parameter int POOL_DEPTH = 16,
  parameter int CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_valid_o,
  input logic [7:0]    tx_data_o,
  input logic          tx_ready_i,
  input logic [7:0]    irq_clr_i,
  input logic [7:0]    irq_pend_o,
  input logic [CW-1:0] assigned_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          overflow_o
);
  assert_odd_parity_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> ($countones(tx_data_o) % 2 == 1));

  assert_offer_after_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(irq_clr_i[7]));

  assert_offer_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  assert_count_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i) |=> (assigned_o == $past(assigned_o) + 1'b1));

  assert_request_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pend_o[7]) |-> (!tx_valid_o && busy_o));

  assert_end_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && overflow_o));

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(assigned_o) <= POOL_DEPTH);
endmodule

bind dyn_addr_dispenser dyn_addr_dispenser_chk #(.POOL_DEPTH(POOL_DEPTH), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
  .tx_ready_i(tx_ready_i), .irq_clr_i(irq_clr_i), .irq_pend_o(irq_pend_o),
  .assigned_o(assigned_o), .busy_o(busy_o), .done_o(done_o), .overflow_o(overflow_o)
);

// File: tb/dyn_addr_dispenser_tb.sv
module dyn_addr_dispenser_tb;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic pool_push = 0, pool_flush = 0, round_start = 0, rx_valid = 0, no_ack = 0, tx_ready = 0;
  logic [6:0] pool_addr = '0;
  logic [7:0] rx_data = '0, irq_mask = 8'h80, irq_clr = '0;
  logic tx_valid, irq, busy, done, ovf;
  logic [7:0] tx_data, pend;
  logic [47:0] id;
  logic [CW-1:0] assigned;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dyn_addr_dispenser #(.POOL_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pool_push_i(pool_push), .pool_addr_i(pool_addr),
    .pool_flush_i(pool_flush), .round_start_i(round_start), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .no_ack_i(no_ack), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_ready_i(tx_ready), .irq_mask_i(irq_mask), .irq_clr_i(irq_clr), .irq_pend_o(pend),
    .irq_o(irq), .id_o(id), .assigned_o(assigned), .busy_o(busy), .done_o(done),
    .overflow_o(ovf)
  );

  function automatic logic [7:0] exp_byte(input logic [6:0] a);
    return {a, ($countones(a) % 2 == 0) ? 1'b1 : 1'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [6:0] a);
    pool_push = 1; pool_addr = a; tick(); pool_push = 0;
  endtask

  task automatic pulse_start();
    round_start = 1; tick(); round_start = 0;
  endtask

  task automatic send_id(input logic [47:0] v);
    for (int i = 5; i >= 0; i--) begin
      rx_valid = 1; rx_data = v[8*i +: 8]; tick();
    end
    rx_valid = 0;
  endtask

  task automatic serve_target(input logic [47:0] v, input logic [6:0] a, input int idx);
    send_id(v);
    chk(id == v, "R3 id capture", id, v);
    chk(pend[7] == 1'b1, "R4 request bit set", pend, 8'h80);
    chk(tx_valid == 1'b0, "R6 no offer before ack", tx_valid, 0);
    irq_mask = 8'h00; #1;
    chk(irq == 1'b0, "R4 masked irq", irq, 0);
    irq_mask = 8'h80; #1;
    chk(irq == 1'b1, "R4 enabled irq", irq, 1);
    rx_valid = 1; rx_data = 8'hEE; tick(); rx_valid = 0;
    chk(id == v, "R3 byte ignored while waiting", id, v);
    chk(tx_valid == 1'b0, "R6 still no offer", tx_valid, 0);
    irq_clr = 8'h80; tick(); irq_clr = 0;
    chk(pend[7] == 1'b0, "R5 request cleared", pend, 0);
    chk(tx_valid == 1'b1, "R6 offer after ack", tx_valid, 1);
    chk(tx_data == exp_byte(a), "R6 address byte", tx_data, exp_byte(a));
    chk(int'(assigned) == idx, "R7 count before", assigned, idx);
    tick();
    chk(tx_valid == 1'b1 && tx_data == exp_byte(a), "R7 offer held", tx_data, exp_byte(a));
    tx_ready = 1; tick(); tx_ready = 0;
    chk(tx_valid == 1'b0, "R7 offer taken", tx_valid, 0);
    chk(int'(assigned) == idx + 1, "R7 count step", assigned, idx + 1);
  endtask

  task automatic test_reset();
    repeat (3) tick();
    rst_n = 1; tick();
    chk(pend == 8'h00 && !irq, "R1 pend/irq", pend, 0);
    chk(!tx_valid && !busy && !done && !ovf, "R1 flags", {tx_valid, busy, done, ovf}, 0);
    chk(assigned == '0, "R1 count", assigned, 0);
  endtask

  task automatic test_normal_round();
    push(7'h08); push(7'h0B); push(7'h51);
    pulse_start();
    chk(busy && assigned == '0, "R10 start", {busy, assigned}, 1 << CW);
    serve_target(48'h0A1B2C3D4E5F, 7'h08, 0);
    serve_target(48'h112233445566, 7'h0B, 1);
    serve_target(48'hFEDCBA987654, 7'h51, 2);
    no_ack = 1; tick(); no_ack = 0;
    chk(done && !busy && !ovf, "R8 normal end", {done, busy, ovf}, 3'b100);
    chk(pend == 8'h01, "R8 done pending", pend, 8'h01);
    chk(int'(assigned) == 3, "R8 count kept", assigned, 3);
    irq_clr = 8'h02; tick(); irq_clr = 0;
    chk(pend == 8'h01, "R5 zero-bit clear no effect", pend, 8'h01);
    irq_clr = 8'h01; tick(); irq_clr = 0;
    chk(pend == 8'h00, "R5 w1c", pend, 0);
  endtask

  task automatic test_overflow();
    pool_flush = 1; tick(); pool_flush = 0;
    push(7'h22);
    pulse_start();
    chk(!done, "R10 status cleared", done, 0);
    serve_target(48'h010203040506, 7'h22, 0);
    pulse_start();
    chk(busy && int'(assigned) == 1, "R10 start ignored when busy", assigned, 1);
    push(7'h33);
    send_id(48'hA0A1A2A3A4A5);
    chk(ovf && !busy, "R9 overflow stop", {ovf, busy}, 2'b10);
    chk(pend == 8'h02, "R9 overflow pending, no request", pend, 8'h02);
    chk(tx_valid == 1'b0, "R2 push while busy ignored", tx_valid, 0);
    chk(int'(assigned) == 1, "R9 count", assigned, 1);
  endtask

  task automatic test_restart();
    irq_clr = 8'hFF; tick(); irq_clr = 0;
    pool_flush = 1; pool_push = 0; round_start = 0;
    pool_flush = 0;
    pulse_start();
    chk(assigned == '0 && !ovf && busy, "R10 restart clears", {assigned, ovf}, 0);
    serve_target(48'h5A5A5A5A5A5A, 7'h22, 0);
    no_ack = 1; irq_clr = 8'h01; tick(); no_ack = 0; irq_clr = 0;
    chk(pend[0] == 1'b1, "R5 set wins over clear", pend, 8'h01);
    chk(done && !busy, "R8 second end", {done, busy}, 2'b10);
  endtask

  initial begin
    test_reset();
    test_normal_round();
    test_overflow();
    test_restart();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule